// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block turns single-word host requests into correctly timed NAND flash bus cycles. A request names one of three regions (data, command or address) and a direction. Command and address requests become latch-enable cycles: the command latch is raised for the command region and the address latch for the address region. Data requests become plain transfers with neither latch raised. The block generates chip enable, the write and read strobes and the output enable of the bidirectional data bus, and it returns read data with a one-cycle response pulse.

Two timing sets are held in configuration storage. Data transfers use the data set, and command/address cycles use the control set. Each set holds four phase counts: setup, strobe, hold and bus release. A control word selects the bus width and two turnaround delays. One delay applies when a data read directly follows a command cycle, and the other when it directly follows an address cycle. The timing in force is captured when a request is accepted. An external ready input can stretch the strobe.

Top module: `nfc_bus_seq`

## Requirements
- R1: After reset, the outputs are idle: nand_ce_n, nand_we_n and nand_re_n are 1, and nand_cle, nand_ale, nand_dq_oe, busy and rsp_valid are 0. Both timing sets reset to 10 in every phase field. Both turnaround fields reset to 15, and the bus is 8 bits wide.
- R2: A timing word keeps setup in bits [7:0], strobe in [15:8], hold in [23:16] and bus release in [31:24]. A transfer holds nand_ce_n low with both strobes high for the setup count, then holds its strobe low for the strobe count, then holds nand_ce_n low with both strobes high for the hold count. A setup, strobe or hold field of 0 acts as 1.
- R3: req_space 0 is data, 1 is command and 2 is address. Command and address requests use the control set (cfg_sel 1); data requests use the data set (cfg_sel 0). nand_cle is high for the whole enable window of a command cycle, and nand_ale for the whole enable window of an address cycle. Command and address cycles carry one byte on nand_dq_o[7:0], with the upper lane at 0.
- R4: A read samples nand_dq_i in the last strobe cycle. It returns the sample on rsp_rdata with a one-cycle rsp_valid pulse in the first cycle after the hold ends, when busy is already low.
- R5: On a write, nand_dq_oe is high from the first strobe cycle through the last hold cycle, and nand_dq_o holds the write value there. On reads and while idle, nand_dq_oe is 0.
- R6: After a write ends, nand_ce_n stays high for at least max(R,1) cycles before the next transfer, where R is the release count of the write's set. If the next request arrives in the first idle cycle, the gap is exactly max(R,1) cycles.
- R7: The control word (cfg_sel 2) holds the command turnaround in bits [12:9] and the address turnaround in [16:13]. A data read that directly follows a command cycle gets field+1 extra cycles of enable before its setup. A read after an address cycle gets the address field+1. A read after a data transfer gets none.
- R8: Control word bits [5:4] equal to 1 select a 16-bit data bus. Any other value selects 8 bits, and then data writes and reads keep the upper byte at 0.
- R9: busy rises at the edge that accepts a request and falls at the edge that ends the hold. A request raised while busy is high is ignored and produces no bus cycle.
- R10: The timing set, turnaround delay and width in force are those present at acceptance. Configuration writes during a transfer apply only to later requests.
- R11: While nand_rdy is low, the strobe is held past its count. It is released at the first edge where the count has elapsed and nand_rdy is high.
- R12: The write and read strobes are never low together, and nand_cle and nand_ale are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 data set, 1 control set, 2 control word |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_write | input | 1 | 1 write, 0 read |
| req_space | input | 2 | 0 data, 1 command, 2 address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transfer in progress |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rdy | input | 1 | Ready; low stretches the strobe |
| nand_dq_i | input | 16 | Data bus input |
| nand_dq_o | output | 16 | Data bus output |
| nand_dq_oe | output | 1 | Data bus output enable |

## Verification
The exact bus-release gap and the turnaround delays are hard to reach from the ports. Both appear only when the next request arrives in the very first idle cycle after the previous hold. The driver therefore issues a request at the first falling clock edge where busy is low, and each queued item carries the exact gap and enable-before-strobe count expected. Sequences of command-then-read and address-then-read run with distinct turnaround values, so the two delays cannot be confused. The strobe stretch is reached by holding ready low across a strobe whose count is already spent. A configuration rewrite lands inside a running transfer to show that the captured timing holds.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    // Region codes carried on req_space
    localparam logic [1:0] SP_DATA = 2'd0;
    localparam logic [1:0] SP_CMD  = 2'd1;
    localparam logic [1:0] SP_ADDR = 2'd2;

    // Index of each phase field inside a timing word
    localparam int PH_SETUP = 0;
    localparam int PH_STRB  = 1;
    localparam int PH_HOLD  = 2;
    localparam int PH_HIZ   = 3;
    localparam int PH_NUM   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_DLY,
        ST_SETUP,
        ST_STRB,
        ST_HOLD
    } nfc_state_e;

endpackage

// File: rtl/nfc_cfg_regs.sv
module nfc_cfg_regs #(
    parameter int CNT_W = 8,
    parameter int DLY_W = 4,
    localparam int TW = nfc_pkg::PH_NUM * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [TW-1:0]    cfg_wdata,
    output logic [TW-1:0]    data_set,
    output logic [TW-1:0]    ctl_set,
    output logic [DLY_W-1:0] tclr,
    output logic [DLY_W-1:0] tar,
    output logic             wide
);
    localparam int WID_LSB  = 4;
    localparam int TCLR_LSB = 9;
    localparam int TAR_LSB  = TCLR_LSB + DLY_W;
    localparam logic [CNT_W-1:0] PH_RST  = CNT_W'(10);
    localparam logic [TW-1:0]    SET_RST = {nfc_pkg::PH_NUM{PH_RST}};

    typedef struct packed {
        logic [TW-1:0]    dset;
        logic [TW-1:0]    cset;
        logic [DLY_W-1:0] tclr;
        logic [DLY_W-1:0] tar;
        logic             wide;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_sel)
                2'd0: cfg_d.dset = cfg_wdata;
                2'd1: cfg_d.cset = cfg_wdata;
                2'd2: begin
                    cfg_d.wide = (cfg_wdata[WID_LSB +: 2] == 2'd1);
                    cfg_d.tclr = cfg_wdata[TCLR_LSB +: DLY_W];
                    cfg_d.tar  = cfg_wdata[TAR_LSB +: DLY_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.dset <= SET_RST;
            cfg_q.cset <= SET_RST;
            cfg_q.tclr <= '1;
            cfg_q.tar  <= '1;
            cfg_q.wide <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign data_set = cfg_q.dset;
    assign ctl_set  = cfg_q.cset;
    assign tclr     = cfg_q.tclr;
    assign tar      = cfg_q.tar;
    assign wide     = cfg_q.wide;

endmodule

// File: rtl/nfc_phase_pick.sv
module nfc_phase_pick #(
    parameter int CNT_W = 8,
    parameter int DLY_W = 4,
    localparam int TW = nfc_pkg::PH_NUM * CNT_W
) (
    input  logic [1:0]                              space,
    input  logic                                    is_write,
    input  logic [1:0]                              last_space,
    input  logic [TW-1:0]                           data_set,
    input  logic [TW-1:0]                           ctl_set,
    input  logic [DLY_W-1:0]                        tclr,
    input  logic [DLY_W-1:0]                        tar,
    output logic [nfc_pkg::PH_NUM-1:0][CNT_W-1:0]   ph,
    output logic [DLY_W:0]                          pre_dly
);
    import nfc_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [DLY_W:0]   DLY_ONE = (DLY_W+1)'(1);

    logic          use_ctl;
    logic [TW-1:0] sel_set;

    assign use_ctl = (space == SP_CMD) || (space == SP_ADDR);
    assign sel_set = use_ctl ? ctl_set : data_set;

    // Setup, strobe and hold never go below one cycle; release may be zero
    for (genvar g = 0; g < PH_NUM; g++) begin : g_ph
        if (g == PH_HIZ) begin : g_raw
            assign ph[g] = sel_set[g*CNT_W +: CNT_W];
        end else begin : g_clamp
            assign ph[g] = (sel_set[g*CNT_W +: CNT_W] == '0) ? CNT_ONE
                                                             : sel_set[g*CNT_W +: CNT_W];
        end
    end

    // Turnaround only for a data read directly after a latch cycle
    always_comb begin
        pre_dly = '0;
        if (!is_write && !use_ctl) begin
            if (last_space == SP_CMD)
                pre_dly = {1'b0, tclr} + DLY_ONE;
            else if (last_space == SP_ADDR)
                pre_dly = {1'b0, tar} + DLY_ONE;
        end
    end

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq #(
    parameter int CNT_W = 8,
    parameter int DLY_W = 4,
    parameter int DQ_W  = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    input  logic                                    req_write,
    input  logic [1:0]                              req_space,
    input  logic [DQ_W-1:0]                         req_wdata,
    input  logic [nfc_pkg::PH_NUM-1:0][CNT_W-1:0]   pick_ph,
    input  logic [DLY_W:0]                          pick_dly,
    input  logic                                    wide,
    input  logic                                    nand_rdy,
    input  logic [DQ_W-1:0]                         nand_dq_i,
    output logic [1:0]                              last_space,
    output logic                                    busy,
    output logic                                    rsp_valid,
    output logic [DQ_W-1:0]                         rsp_rdata,
    output logic                                    nand_ce_n,
    output logic                                    nand_cle,
    output logic                                    nand_ale,
    output logic                                    nand_we_n,
    output logic                                    nand_re_n,
    output logic [DQ_W-1:0]                         nand_dq_o,
    output logic                                    nand_dq_oe
);
    import nfc_pkg::*;

    localparam int BYTE_W = DQ_W / 2;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        nfc_state_e                     st;
        logic [CNT_W-1:0]               cnt;
        logic [PH_NUM-1:0][CNT_W-1:0]   ph;
        logic [DLY_W:0]                 dly;
        logic                           wr;
        logic [1:0]                     sp;
        logic                           narrow;
        logic [DQ_W-1:0]                wdata;
        logic [CNT_W-1:0]               hiz;
        logic [1:0]                     last;
        logic                           busy;
        logic                           rsp;
        logic [DQ_W-1:0]                rdata;
    } seq_t;

    seq_t s_d, s_q;
    logic req_narrow;
    logic in_win;
    logic latch_ph;

    assign req_narrow = !wide || (req_space == SP_CMD) || (req_space == SP_ADDR);

    always_comb begin
        s_d     = s_q;
        s_d.rsp = 1'b0;
        if (s_q.hiz != '0)
            s_d.hiz = s_q.hiz - CNT_ONE;

        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.busy   = 1'b1;
                    s_d.ph     = pick_ph;
                    s_d.dly    = pick_dly;
                    s_d.wr     = req_write;
                    s_d.sp     = req_space;
                    s_d.last   = req_space;
                    s_d.narrow = req_narrow;
                    s_d.wdata  = req_narrow ? {{(DQ_W-BYTE_W){1'b0}}, req_wdata[BYTE_W-1:0]}
                                            : req_wdata;
                    if (s_q.hiz > CNT_ONE) begin
                        s_d.st = ST_GAP;
                    end else if (pick_dly != '0) begin
                        s_d.st  = ST_DLY;
                        s_d.cnt = CNT_W'(pick_dly) - CNT_ONE;
                    end else begin
                        s_d.st  = ST_SETUP;
                        s_d.cnt = pick_ph[PH_SETUP] - CNT_ONE;
                    end
                end
            end
            ST_GAP: begin
                if (s_q.hiz <= CNT_ONE) begin
                    if (s_q.dly != '0) begin
                        s_d.st  = ST_DLY;
                        s_d.cnt = CNT_W'(s_q.dly) - CNT_ONE;
                    end else begin
                        s_d.st  = ST_SETUP;
                        s_d.cnt = s_q.ph[PH_SETUP] - CNT_ONE;
                    end
                end
            end
            ST_DLY: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_SETUP;
                    s_d.cnt = s_q.ph[PH_SETUP] - CNT_ONE;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_ONE;
                end
            end
            ST_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_STRB;
                    s_d.cnt = s_q.ph[PH_STRB] - CNT_ONE;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_ONE;
                end
            end
            ST_STRB: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - CNT_ONE;
                end else if (nand_rdy) begin
                    s_d.st  = ST_HOLD;
                    s_d.cnt = s_q.ph[PH_HOLD] - CNT_ONE;
                    if (!s_q.wr)
                        s_d.rdata = s_q.narrow
                                  ? {{(DQ_W-BYTE_W){1'b0}}, nand_dq_i[BYTE_W-1:0]}
                                  : nand_dq_i;
                end
            end
            ST_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.st   = ST_IDLE;
                    s_d.busy = 1'b0;
                    s_d.rsp  = !s_q.wr;
                    if (s_q.wr)
                        s_d.hiz = s_q.ph[PH_HIZ];
                end else begin
                    s_d.cnt = s_q.cnt - CNT_ONE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.last <= SP_DATA;
        end else begin
            s_q <= s_d;
        end
    end

    // Pin decode from the registered phase
    assign in_win   = (s_q.st == ST_DLY) || (s_q.st == ST_SETUP) ||
                      (s_q.st == ST_STRB) || (s_q.st == ST_HOLD);
    assign latch_ph = (s_q.st == ST_SETUP) || (s_q.st == ST_STRB) || (s_q.st == ST_HOLD);

    assign nand_ce_n  = !in_win;
    assign nand_cle   = latch_ph && (s_q.sp == SP_CMD);
    assign nand_ale   = latch_ph && (s_q.sp == SP_ADDR);
    assign nand_we_n  = !((s_q.st == ST_STRB) && s_q.wr);
    assign nand_re_n  = !((s_q.st == ST_STRB) && !s_q.wr);
    assign nand_dq_oe = s_q.wr && ((s_q.st == ST_STRB) || (s_q.st == ST_HOLD));
    assign nand_dq_o  = nand_dq_oe ? s_q.wdata : '0;

    assign last_space = s_q.last;
    assign busy       = s_q.busy;
    assign rsp_valid  = s_q.rsp;
    assign rsp_rdata  = s_q.rdata;

endmodule

// File: rtl/nfc_bus_seq.sv
module nfc_bus_seq #(
    parameter int CNT_W = 8,
    parameter int DLY_W = 4,
    parameter int DQ_W  = 16,
    localparam int TW = nfc_pkg::PH_NUM * CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [TW-1:0]   cfg_wdata,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [1:0]      req_space,
    input  logic [DQ_W-1:0] req_wdata,
    output logic            busy,
    output logic            rsp_valid,
    output logic [DQ_W-1:0] rsp_rdata,
    output logic            nand_ce_n,
    output logic            nand_cle,
    output logic            nand_ale,
    output logic            nand_we_n,
    output logic            nand_re_n,
    input  logic            nand_rdy,
    input  logic [DQ_W-1:0] nand_dq_i,
    output logic [DQ_W-1:0] nand_dq_o,
    output logic            nand_dq_oe
);
    logic [TW-1:0]                            data_set;
    logic [TW-1:0]                            ctl_set;
    logic [DLY_W-1:0]                         tclr;
    logic [DLY_W-1:0]                         tar;
    logic                                     wide;
    logic [1:0]                               last_space;
    logic [nfc_pkg::PH_NUM-1:0][CNT_W-1:0]    pick_ph;
    logic [DLY_W:0]                           pick_dly;

    nfc_cfg_regs #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .data_set  (data_set),
        .ctl_set   (ctl_set),
        .tclr      (tclr),
        .tar       (tar),
        .wide      (wide)
    );

    nfc_phase_pick #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_pick (
        .space      (req_space),
        .is_write   (req_write),
        .last_space (last_space),
        .data_set   (data_set),
        .ctl_set    (ctl_set),
        .tclr       (tclr),
        .tar        (tar),
        .ph         (pick_ph),
        .pre_dly    (pick_dly)
    );

    nfc_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W), .DQ_W(DQ_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_space  (req_space),
        .req_wdata  (req_wdata),
        .pick_ph    (pick_ph),
        .pick_dly   (pick_dly),
        .wide       (wide),
        .nand_rdy   (nand_rdy),
        .nand_dq_i  (nand_dq_i),
        .last_space (last_space),
        .busy       (busy),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .nand_ce_n  (nand_ce_n),
        .nand_cle   (nand_cle),
        .nand_ale   (nand_ale),
        .nand_we_n  (nand_we_n),
        .nand_re_n  (nand_re_n),
        .nand_dq_o  (nand_dq_o),
        .nand_dq_oe (nand_dq_oe)
    );

endmodule

// File: rtl/nfc_bus_seq_chk.sv
module nfc_bus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic rsp_valid,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe
);
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R12
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R2
    strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe));

    // R5
    drive_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_dq_oe |-> (!nand_ce_n && nand_re_n));

    // R4
    rsp_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!busy && $past(busy)));

    // R9
    busy_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(nand_ce_n));

endmodule

bind nfc_bus_seq nfc_bus_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nfc_bus_seq_tb.sv
`timescale 1ns/1ps
module nfc_bus_seq_tb;

    typedef struct {
        logic [1:0]  sp;
        logic        wr;
        int          pre;
        int          stb;
        int          post;
        logic [15:0] dat;
        int          gap;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_space = '0;
    logic [15:0] req_wdata = '0;
    logic        nand_rdy = 1'b1;
    logic [15:0] nand_dq_i = 16'hBEEF;
    logic        busy, rsp_valid, nand_ce_n, nand_cle, nand_ale;
    logic        nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] rsp_rdata, nand_dq_o;

    int n_chk = 0;
    int n_fail = 0;
    item_t       exp_q[$];
    logic [15:0] rd_q[$];

    always #2.5 clk = ~clk;

    nfc_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_wdata(req_wdata), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_rdy(nand_rdy), .nand_dq_i(nand_dq_i),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Push expectation, issue at the first idle negedge, return one cycle after
    task automatic xfer(input logic [1:0] sp, input logic wr, input logic [15:0] wd,
                        input int pre, input int stb, input int post,
                        input logic [15:0] dat, input int gap);
        item_t it;
        it.sp = sp; it.wr = wr; it.pre = pre; it.stb = stb; it.post = post;
        it.dat = dat; it.gap = gap;
        exp_q.push_back(it);
        if (!wr) rd_q.push_back(dat);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_space = sp; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (n) @(negedge clk);
    endtask

    // Bus monitor: measures each enable window and compares with the queue head
    bit          in_win = 0;
    int          pre_c, stb_c, post_c, gap_c = 1000;
    bit          cle_s, ale_s, lat_bad, oe_bad, excl_bad;
    logic [15:0] dq_s;
    item_t       cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (nand_cle && nand_ale) excl_bad = 1;
            if (!nand_we_n && !nand_re_n) excl_bad = 1;
            if (!nand_ce_n) begin
                if (!in_win) begin
                    in_win = 1; pre_c = 0; stb_c = 0; post_c = 0;
                    cle_s = nand_cle; ale_s = nand_ale; lat_bad = 0; oe_bad = 0;
                    excl_bad = 0; dq_s = '0;
                    if (exp_q.size() == 0) begin
                        chk(0, "R9", "unexpected bus cycle", 1, 0);
                        cur.sp = 0; cur.wr = 0; cur.gap = -1;
                    end else begin
                        cur = exp_q[0];
                    end
                    if (cur.gap >= 0)
                        chk(gap_c == cur.gap, "R6", "enable-high gap", gap_c, cur.gap);
                end
                if (nand_cle != cle_s || nand_ale != ale_s) lat_bad = 1;
                if (!nand_we_n || !nand_re_n) begin
                    stb_c++;
                    if (!nand_we_n && stb_c == 1) dq_s = nand_dq_o;
                    if (!nand_we_n && nand_dq_o != dq_s) oe_bad = 1;
                end else if (stb_c == 0) pre_c++;
                else post_c++;
                if (nand_dq_oe != (cur.wr && stb_c > 0)) oe_bad = 1;
            end else begin
                if (nand_dq_oe) oe_bad = 1;
                if (in_win) begin
                    in_win = 0; gap_c = 1;
                    if (exp_q.size() > 0) begin
                        cur = exp_q.pop_front();
                        chk(pre_c == cur.pre, "R2", "cycles before strobe", pre_c, cur.pre);
                        chk(stb_c == cur.stb, "R2", "strobe cycles", stb_c, cur.stb);
                        chk(post_c == cur.post, "R2", "hold cycles", post_c, cur.post);
                        chk(cle_s == (cur.sp == 2'd1), "R3", "cle", cle_s, cur.sp == 2'd1);
                        chk(ale_s == (cur.sp == 2'd2), "R3", "ale", ale_s, cur.sp == 2'd2);
                        chk(!lat_bad, "R3", "latch steady in window", lat_bad, 0);
                        chk(!oe_bad, "R5", "output enable window", oe_bad, 0);
                        chk(!excl_bad, "R12", "strobe or latch overlap", excl_bad, 0);
                        if (cur.wr)
                            chk(dq_s == cur.dat, "R8", "write data on bus", dq_s, cur.dat);
                    end
                end else begin
                    gap_c++;
                end
            end
        end
    end

    // Read response monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (rd_q.size() == 0) begin
                chk(0, "R4", "unexpected response", 1, 0);
            end else begin
                logic [15:0] e;
                e = rd_q.pop_front();
                chk(rsp_rdata == e, "R4", "read data", rsp_rdata, e);
                chk(busy == 1'b0, "R4", "busy low at response", busy, 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1", "strobes idle",
            {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1", "latch/oe idle",
            {nand_cle, nand_ale, nand_dq_oe}, 0);
        chk(!busy && !rsp_valid, "R1", "busy/rsp idle", {busy, rsp_valid}, 0);

        // R1 R2 R8: defaults 10/10/10, 8-bit bus
        xfer(2'd0, 1, 16'h12A5, 10, 10, 10, 16'h00A5, -1);
        // R3 R6: back-to-back command, gap equals default release 10
        xfer(2'd1, 1, 16'hFF70, 10, 10, 10, 16'h0070, 10);
        idle(30);

        cfg(2'd0, 32'h03020401);
        cfg(2'd1, 32'h00010203);
        cfg(2'd2, 32'h0000A400);
        idle(20);

        // R7: command then read, turnaround 2+1 plus setup 1
        xfer(2'd1, 1, 16'h0000, 3, 2, 1, 16'h0000, -1);
        xfer(2'd0, 0, 16'h0000, 4, 4, 2, 16'h00EF, 1);
        // R7: address then read, turnaround 5+1 plus setup 1
        xfer(2'd2, 1, 16'h5512, 3, 2, 1, 16'h0012, 1);
        xfer(2'd0, 0, 16'h0000, 7, 4, 2, 16'h00EF, 1);
        // R7: read after read gets no turnaround
        xfer(2'd0, 0, 16'h0000, 1, 4, 2, 16'h00EF, 1);
        // R6: write then write, release 3
        xfer(2'd0, 1, 16'h77C3, 1, 4, 2, 16'h00C3, 1);
        xfer(2'd0, 1, 16'h003C, 1, 4, 2, 16'h003C, 3);
        idle(20);

        // R2: zero fields act as one; release 0 gives gap 1
        cfg(2'd0, 32'h00000000);
        xfer(2'd0, 1, 16'h0011, 1, 1, 1, 16'h0011, -1);
        xfer(2'd0, 1, 16'h0022, 1, 1, 1, 16'h0022, 1);
        idle(20);

        // R8: 16-bit bus
        cfg(2'd0, 32'h03020401);
        cfg(2'd2, 32'h0000A410);
        idle(5);
        xfer(2'd0, 1, 16'h12A5, 1, 4, 2, 16'h12A5, -1);
        xfer(2'd0, 0, 16'h0000, 1, 4, 2, 16'hBEEF, 3);
        xfer(2'd1, 1, 16'hFF70, 3, 2, 1, 16'h0070, 1);
        idle(20);

        // R11: ready low stretches strobe from 2 to 4 cycles
        cfg(2'd0, 32'h00010201);
        idle(5);
        nand_rdy = 1'b0;
        xfer(2'd0, 1, 16'h0044, 1, 4, 1, 16'h0044, -1);
        repeat (4) @(negedge clk);
        nand_rdy = 1'b1;
        idle(20);

        // R10: configuration rewrite during a transfer applies only later
        cfg(2'd0, 32'h00020302);
        idle(5);
        xfer(2'd0, 1, 16'h0055, 2, 3, 2, 16'h0055, -1);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h00010105;
        @(negedge clk);
        cfg_we = 1'b0;
        xfer(2'd0, 1, 16'h0066, 5, 1, 1, 16'h0066, 1);
        // R9: request while busy is ignored
        req_valid = 1'b1; req_write = 1'b1; req_space = 2'd1; req_wdata = 16'h0099;
        @(negedge clk);
        req_valid = 1'b0;
        idle(40);
        chk(exp_q.size() == 0, "R9", "pending bus cycles", exp_q.size(), 0);
        chk(rd_q.size() == 0, "R4", "pending responses", rd_q.size(), 0);
        chk(nand_ce_n && !busy, "R9", "idle after ignored request", {nand_ce_n, busy}, 2'b10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule